// File: doc/BRIEF.md
# Cascadable CAM Status Flags

This block is a small content-addressable store with one occupancy bit per location. It produces the two status lines that a priority chain of such stores needs: a full indication and a multiple-match indication. Each location holds a tag and an active-low occupancy bit, where LOW means occupied and HIGH means empty. Software-visible state, a match address output and test access logic are not part of it.

Work is framed by an active-low enable strobe. An operation commits on the clock edge at which `en_n` is first sampled HIGH after being sampled LOW. At that edge the cycle-type select, the address, the data, the occupancy value, the key and the two cascade inputs are all sampled. A write cycle updates one location and then recomputes the full flag. A compare cycle counts the occupied locations whose tag equals the key and then recomputes the multiple-match flag.

In a chain, each device's `full_n` drives the `full_in_n` of the next lower-priority device, and the top device ties its `full_in_n` LOW. The `mm_pd_n` outputs are pull-down enables for one shared open-drain line, so the system line is the wired-AND of all devices.

Top module: `cam_flag_top`

## Requirements
- R1: While `rst_n` is sampled LOW, every location becomes empty, `full_n` goes HIGH and `mm_pd_n` goes HIGH (released).
- R2: An operation commits only on the clock edge at which `en_n` is sampled HIGH and was sampled LOW at the edge before. `op_cmp`=0 selects a write and `op_cmp`=1 selects a compare. A write stores `wr_data` and `wr_vld_n` at `wr_addr`. Holding `en_n` LOW without a rising edge commits nothing.
- R3: After a write commit with `full_in_n` LOW, `full_n` is LOW exactly when every location is occupied (occupancy bit 0).
- R4: After a write commit with `full_in_n` HIGH, `full_n` is HIGH, whatever the local occupancy.
- R5: `full_n` changes only at a write commit. Changes on `full_in_n` and compare commits between writes leave it unchanged.
- R6: After a compare commit with `match_in_n` HIGH, `mm_pd_n` is LOW exactly when two or more locations matched.
- R7: After a compare commit with `match_in_n` LOW, `mm_pd_n` is LOW exactly when one or more locations matched. With zero matches it is HIGH.
- R8: `mm_pd_n` changes only at a compare commit. Write commits and changes on `match_in_n` between compares leave it unchanged.
- R9: Only occupied locations take part in a compare. An empty location whose stored tag equals the key does not count as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_n | input | 1 | Operation strobe, active low; commits on its rising edge |
| op_cmp | input | 1 | Cycle type: 0 write, 1 compare |
| wr_addr | input | $clog2(DEPTH) | Location written by a write cycle |
| wr_data | input | WIDTH | Tag stored by a write cycle |
| wr_vld_n | input | 1 | Occupancy value stored: 0 occupied, 1 empty |
| cmp_key | input | WIDTH | Key searched by a compare cycle |
| full_in_n | input | 1 | Full indication from the higher-priority device |
| match_in_n | input | 1 | Match indication selecting the match threshold |
| full_n | output | 1 | Full flag, active low |
| mm_pd_n | output | 1 | Pull-down enable for the shared multiple-match line, active low |

## Verification
The bench builds the block with DEPTH=4 and WIDTH=4. With only four locations, a short run of writes fills the whole store, so both the all-occupied case and the single-empty case of the full flag are reached. A 4-bit tag makes key collisions common, so random compares regularly find zero, one and several matches under both settings of the match input. A stale tag left in an emptied location is also easy to hit with a matching key, which exercises the rule that empty locations never match.

// File: rtl/cam_flag_pkg.sv
// Package: shared types for the cascadable CAM status flag block.
// Assumes: nothing beyond IEEE 1800-2017.
package cam_flag_pkg;

    // Cycle type carried on op_cmp.
    typedef enum logic {
        CYC_WRITE   = 1'b0,
        CYC_COMPARE = 1'b1
    } cam_cycle_e;

endpackage

// File: rtl/cam_strobe.sv
// Module: cam_strobe
// Turns the active-low enable strobe into a single-cycle commit pulse on
// the clock edge where en_n is first sampled HIGH after being sampled LOW.
// Assumes en_n is synchronous to clk; reset is synchronous, active low.
module cam_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    output logic commit
);

    logic en_n_q;

    // Remember the previous sampled level of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) en_n_q <= 1'b1;
        else        en_n_q <= en_n;
    end

    assign commit = rst_n & en_n & ~en_n_q;

    // A commit pulse never lasts two cycles.
    assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/cam_store.sv
// Module: cam_store
// Holds DEPTH tags with one active-low occupancy bit each. It applies
// writes, reports whether any location would be empty after a pending
// write, and counts the occupied locations whose tag equals the key.
// Assumes DEPTH >= 2; wr_go is a single-cycle pulse.
module cam_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic          wr_vld_n,
    input  logic [WIDTH-1:0] cmp_key,
    output logic          any_empty_next,
    output logic [CW-1:0] match_cnt
);

    logic [DEPTH-1:0]            vld_n_q;
    logic [DEPTH-1:0][WIDTH-1:0] tag_q;
    logic [DEPTH-1:0]            vld_n_next;
    logic [DEPTH-1:0]            hit;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_loc
            logic sel;
            assign sel = wr_go && (wr_addr == AW'(g));

            // Per-location storage: reset empties, write replaces.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_n_q[g] <= 1'b1;
                    tag_q[g]   <= '0;
                end else if (sel) begin
                    vld_n_q[g] <= wr_vld_n;
                    tag_q[g]   <= wr_data;
                end
            end

            // Occupancy as it will be once a pending write has landed.
            assign vld_n_next[g] = sel ? wr_vld_n : vld_n_q[g];

            // Only occupied locations may hit.
            assign hit[g] = ~vld_n_q[g] && (tag_q[g] == cmp_key);
        end
    endgenerate

    assign any_empty_next = |vld_n_next;

    // Population count of the hit vector.
    always_comb begin
        match_cnt = '0;
        for (int i = 0; i < DEPTH; i++) match_cnt = match_cnt + CW'(hit[i]);
    end

    // Reset leaves every location empty.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (&vld_n_q));

    // A write lands at its address with its occupancy value.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (vld_n_q[$past(wr_addr)] == $past(wr_vld_n)));

endmodule

// File: rtl/cam_flags.sv
// Module: cam_flags
// Registers the cascade full flag on write commits and the multiple-match
// pull-down enable on compare commits, applying the chain rules.
// Assumes wr_go and cmp_go are single-cycle and mutually exclusive.
module cam_flags #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic          cmp_go,
    input  logic          any_empty_next,
    input  logic          full_in_n,
    input  logic [CW-1:0] match_cnt,
    input  logic          match_in_n,
    output logic          full_n,
    output logic          mm_pd_n
);

    logic [CW-1:0] threshold;

    // Match count needed to pull the shared line low.
    assign threshold = match_in_n ? CW'(2) : CW'(1);

    // Full flag: recomputed only when a write commits.
    always_ff @(posedge clk) begin
        if (!rst_n)     full_n <= 1'b1;
        else if (wr_go) full_n <= full_in_n | any_empty_next;
    end

    // Multiple-match pull-down: recomputed only when a compare commits.
    always_ff @(posedge clk) begin
        if (!rst_n)      mm_pd_n <= 1'b1;
        else if (cmp_go) mm_pd_n <= ~(match_cnt >= threshold);
    end

    assert_full_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && any_empty_next) |=> full_n);

    assert_full_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && full_in_n) |=> full_n);

    assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(full_n));

    assert_mm_multi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && match_cnt >= CW'(2)) |=> !mm_pd_n);

    assert_mm_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && match_cnt == '0) |=> mm_pd_n);

    assert_mm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go |=> $stable(mm_pd_n));

endmodule

// File: rtl/cam_flag_top.sv
// Module: cam_flag_top
// Cascadable CAM status flags: strobe decoding, tag store and flag registers.
// Assumes all inputs are synchronous to clk and DEPTH >= 2.
module cam_flag_top #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             op_cmp,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_vld_n,
    input  logic [WIDTH-1:0] cmp_key,
    input  logic             full_in_n,
    input  logic             match_in_n,
    output logic             full_n,
    output logic             mm_pd_n
);
    import cam_flag_pkg::*;

    logic          commit;
    logic          wr_go;
    logic          cmp_go;
    logic          any_empty_next;
    logic [CW-1:0] match_cnt;
    cam_cycle_e    cycle;

    assign cycle  = cam_cycle_e'(op_cmp);
    assign wr_go  = commit && (cycle == CYC_WRITE);
    assign cmp_go = commit && (cycle == CYC_COMPARE);

    cam_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (en_n),
        .commit (commit)
    );

    cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_go          (wr_go),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .wr_vld_n       (wr_vld_n),
        .cmp_key        (cmp_key),
        .any_empty_next (any_empty_next),
        .match_cnt      (match_cnt)
    );

    cam_flags #(.CW(CW)) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_go          (wr_go),
        .cmp_go         (cmp_go),
        .any_empty_next (any_empty_next),
        .full_in_n      (full_in_n),
        .match_cnt      (match_cnt),
        .match_in_n     (match_in_n),
        .full_n         (full_n),
        .mm_pd_n        (mm_pd_n)
    );

endmodule

// File: tb/cam_flag_top_tb.sv
// Bench: behavioural reference model compared with the DUT on every clock.
module cam_flag_top_tb;
    localparam int DEPTH = 4;
    localparam int WIDTH = 4;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1;
    logic op_cmp = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic wr_vld_n = 1'b1;
    logic [WIDTH-1:0] cmp_key = '0;
    logic full_in_n = 1'b0;
    logic match_in_n = 1'b1;
    logic full_n;
    logic mm_pd_n;

    int vectors = 0;
    int miscompares = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    int cycles = 0;
    string phase = "R1";

    // Reference model state.
    int m_vld[DEPTH];
    int m_tag[DEPTH];
    bit m_full_n = 1'b1;
    bit m_mm_n = 1'b1;
    bit m_prev = 1'b1;

    always #5 clk = ~clk;

    cam_flag_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .op_cmp(op_cmp),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_vld_n(wr_vld_n),
        .cmp_key(cmp_key), .full_in_n(full_in_n), .match_in_n(match_in_n),
        .full_n(full_n), .mm_pd_n(mm_pd_n)
    );

    // Reference model, advanced from the inputs at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 1; m_tag[i] = 0; end
            m_full_n = 1'b1; m_mm_n = 1'b1; m_prev = 1'b1;
        end else begin
            if (!m_prev && en_n) begin
                if (!op_cmp) begin
                    bit allv;
                    m_vld[int'(wr_addr)] = int'(wr_vld_n);
                    m_tag[int'(wr_addr)] = int'(wr_data);
                    allv = 1'b1;
                    for (int i = 0; i < DEPTH; i++) if (m_vld[i] != 0) allv = 1'b0;
                    m_full_n = !(allv && !full_in_n);
                end else begin
                    int n;
                    n = 0;
                    for (int i = 0; i < DEPTH; i++)
                        if (m_vld[i] == 0 && m_tag[i] == int'(cmp_key)) n++;
                    m_mm_n = match_in_n ? !(n >= 2) : !(n >= 1);
                end
            end
            m_prev = en_n;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            vectors++;
            if (full_n !== m_full_n) begin
                miscompares++;
                $display("FAIL %s full_n actual=%b expected=%b t=%0t", phase, full_n, m_full_n, $time);
            end
            if (mm_pd_n !== m_mm_n) begin
                miscompares++;
                $display("FAIL %s mm_pd_n actual=%b expected=%b t=%0t", phase, mm_pd_n, m_mm_n, $time);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic do_op(input bit cmp, input int a, input int d, input bit v,
                         input bit fi, input bit mi);
        @(negedge clk);
        op_cmp = cmp; wr_addr = AW'(a); wr_data = WIDTH'(d); wr_vld_n = v;
        cmp_key = WIDTH'(d); full_in_n = fi; match_in_n = mi; en_n = 1'b0;
        @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_pins(input string req, input bit f, input bit m);
        vectors++;
        if (full_n !== f || mm_pd_n !== m) begin
            miscompares++;
            $display("FAIL %s pins actual=%b%b expected=%b%b", req, full_n, mm_pd_n, f, m);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        phase = "R1"; expect_pins("R1", 1'b1, 1'b1);

        // R3: fill all four locations, full only after the last.
        phase = "R3";
        for (int i = 0; i < DEPTH; i++) do_op(1'b0, i, i + 1, 1'b0, 1'b0, 1'b1);
        expect_pins("R3", 1'b0, 1'b1);

        // R5: full_in_n moves and strobe held low, no commit.
        phase = "R5";
        @(negedge clk); full_in_n = 1'b1; en_n = 1'b0;
        repeat (4) @(negedge clk);
        expect_pins("R5", 1'b0, 1'b1);
        en_n = 1'b1; op_cmp = 1'b1; cmp_key = 4'd9; match_in_n = 1'b0;
        @(negedge clk);
        expect_pins("R5", 1'b0, 1'b1);

        // R4: upstream not full forces full_n high.
        phase = "R4";
        do_op(1'b0, 2, 3, 1'b0, 1'b1, 1'b1);
        expect_pins("R4", 1'b1, 1'b1);
        do_op(1'b0, 2, 3, 1'b0, 1'b0, 1'b1);
        expect_pins("R4", 1'b0, 1'b1);

        // R6 / R7: tags now 1,2,3,4. Make two locations hold 5.
        phase = "R6";
        do_op(1'b0, 0, 5, 1'b0, 1'b0, 1'b1);
        do_op(1'b0, 1, 5, 1'b0, 1'b0, 1'b1);
        do_op(1'b1, 0, 5, 1'b0, 1'b0, 1'b1);
        expect_pins("R6", 1'b0, 1'b0);
        do_op(1'b1, 0, 3, 1'b0, 1'b0, 1'b1);
        expect_pins("R6", 1'b0, 1'b1);
        phase = "R7";
        do_op(1'b1, 0, 3, 1'b0, 1'b0, 1'b0);
        expect_pins("R7", 1'b0, 1'b0);
        do_op(1'b1, 0, 11, 1'b0, 1'b0, 1'b0);
        expect_pins("R7", 1'b0, 1'b1);

        // R8: write after a match keeps mm_pd_n.
        phase = "R8";
        do_op(1'b1, 0, 5, 1'b0, 1'b0, 1'b0);
        do_op(1'b0, 3, 7, 1'b1, 1'b0, 1'b1);
        expect_pins("R8", 1'b1, 1'b0);
        @(negedge clk); match_in_n = 1'b1;
        @(negedge clk);
        expect_pins("R8", 1'b1, 1'b0);

        // R9: location 3 is empty with stale tag 7.
        phase = "R9";
        do_op(1'b1, 0, 7, 1'b0, 1'b0, 1'b0);
        expect_pins("R9", 1'b1, 1'b1);

        // R2: random mix checked against the model each cycle.
        phase = "R2";
        for (int k = 0; k < 400; k++)
            do_op(1'($urandom_range(0, 1)), int'($urandom_range(0, DEPTH - 1)),
                  int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
                  1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)));

        // R1: reset mid-run restores the reset state.
        phase = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        expect_pins("R1", 1'b1, 1'b1);

        done = 1'b1;
        running = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule